// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single DMA channel that copies a run of data units from a source address to a destination address. Software programs four registers: the source address, the destination address, a 24-bit unit count and a control word. It then sets the enable bit. The channel asks a shared arbiter for the bus with `req` and waits for `gnt`. For each unit it issues one read command at the current source address and then one write command at the current destination address. Each command holds until the memory side returns `mem_ready`.

After each unit both addresses move according to their own mode, which is fixed, increment or decrement, by the unit size of 1, 2, 4 or 16 bytes, and the count drops by one. In cycle-steal pacing the channel gives up the bus after every unit. In burst pacing it keeps the bus until the run ends. When the count runs out the end flag is set, and if the interrupt is enabled `irq` rises. A build option lets the source address return to its programmed value after every unit, so one fixed source block can feed a moving destination.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the four registers read as zero and `req`, `mem_valid` and `irq` are low. Register select codes: 0 source, 1 destination, 2 count, 3 control. A write takes effect at the next clock edge. Readback is combinational from `reg_sel`.
- R2: Each unit is a read command (`mem_we`=0, address = source) followed by a write command (`mem_we`=1, address = destination). `mem_size` carries the unit size code. Each command is held unchanged until `mem_ready` is high.
- R3: Control bits [7:6] set the source mode and bits [9:8] set the destination mode. The codes are 0 fixed, 1 increment, 2 decrement and 3 fixed. A moving address steps by the unit byte size after each unit.
- R4: Control bits [5:4] set the unit size: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 16 bytes.
- R5: The count register keeps 24 bits and drops by one per unit. The run ends when it reaches zero. Loading zero means 2^24 units: after n units the count reads 2^24−n and the end flag stays clear.
- R6: Control bit [3] selects pacing. With 0 (cycle-steal), `req` is low for at least one cycle after every unit. With 1 (burst), `req` stays high and the next read starts in the cycle after the write is accepted.
- R7: Control bit [0] enables the channel. `req` rises only while the channel is enabled and the end flag (control bit [1]) is clear. The end flag is set when the run ends. Writing control with bit [1]=0 clears it, and so does a control write that turns bit [0] from 0 to 1. Clearing bit [0] stops the run at the next unit boundary.
- R8: `irq` equals the end flag ANDed with control bit [2].
- R9: When built with `RELOAD_EN`=1 and control bit [10] is set, the source address goes back to its last programmed value after every unit, whatever the source mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data |
| req | output | 1 | Bus request to arbiter |
| gnt | input | 1 | Bus grant from arbiter |
| mem_valid | output | 1 | Memory command valid |
| mem_we | output | 1 | Command is a write |
| mem_addr | output | AW | Command address |
| mem_size | output | 2 | Unit size code |
| mem_ready | input | 1 | Memory accepts command |
| irq | output | 1 | Transfer-end interrupt |

## Verification
A control write that enables the channel raises `req` one cycle later. With the grant tied to the request, the read command appears one cycle after that. The write follows one cycle after the read is accepted. The addresses, the count, the end flag and `irq` all change one cycle after the write is accepted. The bench drives inputs and samples outputs on falling edges, so each of these results is read half a cycle after the edge that produces it. A monitor logs every accepted command and every unit boundary at the falling edge. Address checks and pacing checks are therefore made against that log after the run, not at guessed cycle numbers. Memory stalls are included, so the commands are also checked to hold steady across several cycles.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW        = 32,
  parameter int CW        = 24,
  parameter int RELOAD_EN = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          req,
  input  logic          gnt,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  input  logic          mem_ready,
  output logic          irq
);
  localparam bit HAS_RLD = (RELOAD_EN != 0);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_GAP} state_t;
  state_t state;

  logic [AW-1:0] src, src_init, dst;
  logic [CW-1:0] cnt;
  logic          en, tend, ie, burst, rld;
  logic [1:0]    usz, sm, dm;
  logic [4:0]    stepb;
  logic          unit_done, last;

  assign stepb     = (usz == 2'd3) ? 5'd16 : (5'd1 << usz);
  assign unit_done = (state == S_WR) && mem_ready;
  assign last      = (cnt == CW'(1));

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] mode,
                                              input logic [4:0] s);
    case (mode)
      2'd1:    return a + AW'(s);
      2'd2:    return a - AW'(s);
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; src_init <= '0; dst <= '0; cnt <= '0;
      en <= 1'b0; tend <= 1'b0; ie <= 1'b0; burst <= 1'b0; rld <= 1'b0;
      usz <= '0; sm <= '0; dm <= '0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin src <= reg_wdata; src_init <= reg_wdata; end
          2'd1: dst <= reg_wdata;
          2'd2: cnt <= reg_wdata[CW-1:0];
          default: begin
            en    <= reg_wdata[0];
            tend  <= tend & reg_wdata[1] & ~(reg_wdata[0] & ~en);
            ie    <= reg_wdata[2];
            burst <= reg_wdata[3];
            usz   <= reg_wdata[5:4];
            sm    <= reg_wdata[7:6];
            dm    <= reg_wdata[9:8];
            rld   <= reg_wdata[10] & HAS_RLD;
          end
        endcase
      end
      if (unit_done) begin
        src <= (HAS_RLD && rld) ? src_init : step_addr(src, sm, stepb);
        dst <= step_addr(dst, dm, stepb);
        cnt <= cnt - CW'(1);
        if (last) tend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE: if (req && gnt) state <= S_RD;
        S_RD:   if (mem_ready) state <= S_WR;
        S_WR:   if (mem_ready) begin
                  if (last || !en) state <= S_IDLE;
                  else if (burst)  state <= S_RD;
                  else             state <= S_GAP;
                end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req       = (state == S_RD) || (state == S_WR) || ((state == S_IDLE) && en && !tend);
  assign mem_valid = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_WR) ? dst : src;
  assign mem_size  = usz;
  assign irq       = tend & ie;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: reg_rdata = src;
      2'd1: reg_rdata = dst;
      2'd2: reg_rdata[CW-1:0] = cnt;
      default: begin
        reg_rdata[0]   = en;
        reg_rdata[1]   = tend;
        reg_rdata[2]   = ie;
        reg_rdata[3]   = burst;
        reg_rdata[5:4] = usz;
        reg_rdata[7:6] = sm;
        reg_rdata[9:8] = dm;
        reg_rdata[10]  = rld;
      end
    endcase
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !reg_we |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we |=> mem_valid && mem_we); // R2
  AST_STEAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && !burst && !last |=> !req); // R6
  AST_BURST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && burst && !last && en |=> req && mem_valid && !mem_we); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> cnt == $past(cnt) - CW'(1)); // R5
  AST_END_SET: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && last |=> tend && !req); // R7
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(unit_done) || ($past(reg_we) && $past(reg_sel) == 2'd3)); // R8
endmodule

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        req, gnt, mem_valid, mem_we, mem_ready, irq;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        stall = 1'b0, ph = 1'b0;

  int n_chk = 0, n_fail = 0;
  int n_log = 0, gaps = 0;
  logic        log_we   [0:511];
  logic [31:0] log_addr [0:511];
  logic [1:0]  log_size [0:511];
  logic        prev_wr = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) ph <= ~ph;
  assign mem_ready = stall ? ph : 1'b1;
  assign gnt = req;

  dma_chan_seq #(.AW(32), .CW(24), .RELOAD_EN(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req(req), .gnt(gnt), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_ready(mem_ready), .irq(irq));

  always @(negedge clk) begin
    if (prev_wr && !req) gaps++;
    prev_wr = mem_valid && mem_ready && mem_we;
    if (mem_valid && mem_ready && n_log < 512) begin
      log_we[n_log] = mem_we; log_addr[n_log] = mem_addr; log_size[n_log] = mem_size;
      n_log++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit e, input bit i, input bit b, input int sz,
                                      input int s, input int dd, input bit r);
    return 32'(e) | (32'(i) << 2) | (32'(b) << 3) | (32'(sz) << 4) | (32'(s) << 6)
         | (32'(dd) << 8) | (32'(r) << 10);
  endfunction

  task automatic wait_end();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); rd(2'd3, v);
      if (v[1]) return;
    end
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr(2'd3, 32'd0); wr(2'd0, s); wr(2'd1, d); wr(2'd2, c);
  endtask

  task automatic check_units(input string tag, input int base, input int units,
                             input logic [31:0] s0, input int sstep,
                             input logic [31:0] d0, input int dstep, input logic [1:0] sz);
    for (int i = 0; i < units; i++) begin
      check({tag, " read we"},   32'(log_we[base+2*i]), 32'd0);
      check({tag, " read addr"}, log_addr[base+2*i], s0 + 32'(sstep * i));
      check({tag, " write we"},  32'(log_we[base+2*i+1]), 32'd1);
      check({tag, " write addr"}, log_addr[base+2*i+1], d0 + 32'(dstep * i));
    end
    check({tag, " size"}, 32'(log_size[base]), 32'(sz));
    check({tag, " cmd count"}, 32'(n_log - base), 32'(2 * units));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); check("R1 reset reg", v, 32'd0);
    end
    check("R1 reset req/valid/irq", {29'd0, req, mem_valid, irq}, 32'd0);
  endtask

  task automatic t_disabled();
    int b;
    setup(32'h40, 32'h80, 32'd3);
    b = n_log;
    repeat (10) @(negedge clk);
    check("R7 no req while disabled", 32'(req), 32'd0);
    check("R7 no cmds while disabled", 32'(n_log - b), 32'd0);
  endtask

  task automatic t_steal_inc();
    int b, g; logic [31:0] v;
    setup(32'h1000, 32'h2000, 32'd5);
    b = n_log; g = gaps;
    wr(2'd3, ctl(1, 1, 0, 2, 1, 1, 0));
    wait_end(); repeat (2) @(negedge clk);
    check_units("R2 R3 R4 inc4", b, 5, 32'h1000, 4, 32'h2000, 4, 2'd2);
    check("R6 cycle-steal gaps", 32'(gaps - g), 32'd5);
    rd(2'd2, v); check("R5 count end", v, 32'd0);
    rd(2'd0, v); check("R3 src final", v, 32'h1014);
    rd(2'd1, v); check("R3 dst final", v, 32'h2014);
    rd(2'd3, v); check("R7 end flag", 32'(v[1]), 32'd1);
    check("R8 irq on", 32'(irq), 32'd1);
  endtask

  task automatic t_burst_dec();
    int b, g; logic [31:0] v;
    setup(32'h8000, 32'h3000, 32'd4);
    check("R7 write clears end", 32'(irq), 32'd0);
    b = n_log; g = gaps; stall = 1'b1;
    wr(2'd3, ctl(1, 1, 1, 3, 2, 0, 0));
    wait_end(); repeat (2) @(negedge clk); stall = 1'b0;
    check_units("R2 R3 R4 dec16", b, 4, 32'h8000, -16, 32'h3000, 0, 2'd3);
    check("R6 burst gaps", 32'(gaps - g), 32'd1);
    rd(2'd0, v); check("R3 src dec final", v, 32'h7FC0);
  endtask

  task automatic t_reserved_small();
    int b;
    setup(32'h100, 32'h400, 32'd3);
    b = n_log;
    wr(2'd3, ctl(1, 0, 0, 1, 1, 3, 0));
    wait_end(); repeat (2) @(negedge clk);
    check_units("R3 R4 mode3 size2", b, 3, 32'h100, 2, 32'h400, 0, 2'd1);
    check("R8 irq masked", 32'(irq), 32'd0);
    setup(32'h50, 32'h60, 32'd2);
    b = n_log;
    wr(2'd3, ctl(1, 0, 0, 0, 2, 1, 0));
    wait_end(); repeat (2) @(negedge clk);
    check_units("R3 R4 size1", b, 2, 32'h50, -1, 32'h60, 1, 2'd0);
  endtask

  task automatic t_end_hold_and_zero();
    int b; logic [31:0] v;
    b = n_log;
    repeat (20) @(negedge clk);
    check("R7 no req with end set", 32'(req), 32'd0);
    check("R7 no cmds with end set", 32'(n_log - b), 32'd0);
    wr(2'd2, 32'd0);
    b = n_log;
    wr(2'd3, ctl(1, 0, 0, 0, 0, 0, 0));
    repeat (30) @(negedge clk);
    wr(2'd3, ctl(0, 0, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    v = 0;
    for (int i = b; i < n_log; i++) if (log_we[i]) v++;
    check("R5 zero count ran", 32'(v > 0), 32'd1);
    rd(2'd2, v);
    begin
      int nw = 0;
      for (int i = b; i < n_log; i++) if (log_we[i]) nw++;
      check("R5 zero means 2^24", v, (32'h0100_0000 - 32'(nw)) & 32'hFF_FFFF);
    end
    rd(2'd3, v); check("R5 no end after zero load", 32'(v[1]), 32'd0);
  endtask

  task automatic t_reload();
    int b; logic [31:0] v;
    setup(32'hA00, 32'hB00, 32'd3);
    b = n_log;
    wr(2'd3, ctl(1, 1, 0, 2, 1, 1, 1));
    wait_end(); repeat (2) @(negedge clk);
    check_units("R9 reload", b, 3, 32'hA00, 0, 32'hB00, 4, 2'd2);
    rd(2'd0, v); check("R9 src restored", v, 32'hA00);
    wr(2'd3, ctl(0, 1, 0, 2, 1, 1, 1) | 32'h2);
    rd(2'd3, v); check("R7 end kept on disable", 32'(v[1]), 32'd1);
    wr(2'd3, ctl(1, 1, 0, 2, 1, 1, 1) | 32'h2);
    rd(2'd3, v); check("R7 re-enable clears end", 32'(v[1]), 32'd0);
    wr(2'd3, 32'd0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_steal_inc();
    t_burst_dec();
    t_reserved_small();
    t_end_hold_and_zero();
    t_reload();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule